// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block sits between a single request port and a DRAM command stage. Incoming requests carry an address, a read/write flag and a tag, and are parked in one of two queues: one for reads and one for writes, each `DEPTH` entries deep (32 by default). Every cycle the block offers exactly one pending request to the command stage. The offered request is removed in the cycle the command stage accepts it.

The scheduler keeps a table of the open row in each bank. The command stage updates this table by reporting each activate and each precharge. Two selection policies are available through an input:
- **Strict arrival order:** the oldest entry of the serving queue is offered.
- **Row-hit first:** the oldest entry whose bank already holds its row open is offered, falling back to the oldest entry when no entry hits.

A page-policy input chooses between two treatments of rows:
- **Open page:** rows stay open after an access.
- **Close page:** every access counts as a miss and the bank is closed after the access.

Reads are served ahead of writes. Writes are drained once the write queue fills up to a percentage threshold, and they are also served whenever no read is waiting. Any sharing between several masters belongs in front of this block.

Top module: `rowhit_sched`

## Requirements
- R1: The address is split into column bits [COL_W-1:0], bank bits [COL_W+BANK_W-1:COL_W] and row bits above them (defaults: column [3:0], bank [6:4], row [15:7]). A request hits when its bank is marked open with the same row. `issueHit` reports the hit state of the offered request.
- R2: `reqReady` is low when the queue selected by `reqWrite` holds `DEPTH` entries, and high otherwise. A request is stored when `reqValid` and `reqReady` are both high.
- R3: With `rowHitMode` low, the offered request is the oldest entry of the serving queue.
- R4: With `rowHitMode` high, the offered request is the oldest hitting entry of the serving queue. When no entry in that queue hits, it is the oldest entry.
- R5: While the write count is below the drain level and at least one read is pending, a read is offered (`issueWrite` low).
- R6: The drain level is floor(DEPTH*WR_THRESH_PCT/100), which is 22 by default. While the write count is at or above this level, a write is offered (`issueWrite` high).
- R7: When no read is pending and at least one write is pending, a write is offered.
- R8: After reset all banks are closed. An activate event (`bankEvtValid`, `bankEvtAct`=1) marks the bank open with `bankEvtRow`. A precharge event (`bankEvtAct`=0) marks it closed.
- R9: With `pageOpen` low, `issueHit` is always 0, and an accepted request closes its bank. An event for the same bank in the same cycle overrides this closing.
- R10: The offered entry is removed in the cycle `issueValid` and `issueReady` are both high. The remaining entries keep their order, and a request can be stored in the same cycle.
- R11: `issueValid` is high exactly when either queue holds an entry. After reset both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowHitMode | input | 1 | 1: row-hit first, 0: strict arrival order |
| pageOpen | input | 1 | 1: open page policy, 0: close page policy |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Target queue has room |
| reqWrite | input | 1 | 1: write request, 0: read request |
| reqAddr | input | COL_W+BANK_W+ROW_W | Request address |
| reqTag | input | TAG_W | Request tag |
| issueValid | output | 1 | A request is offered |
| issueReady | input | 1 | Command stage takes the offered request |
| issueWrite | output | 1 | Offered request is a write |
| issueAddr | output | COL_W+BANK_W+ROW_W | Offered address |
| issueTag | output | TAG_W | Offered tag |
| issueHit | output | 1 | Offered request hits an open row |
| bankEvtValid | input | 1 | Bank state event present |
| bankEvtAct | input | 1 | 1: activate, 0: precharge |
| bankEvtBank | input | BANK_W | Bank of the event |
| bankEvtRow | input | ROW_W | Row opened by an activate |

## Verification
The bound assertions check the following properties on every cycle:
- full-queue back-pressure on reads;
- count bookkeeping against the push and pop strobes;
- the read-versus-write choice on both sides of the drain level;
- the absence of hits under the close policy;
- the empty-implies-idle rule.

Which entry is picked within a queue can only be shown by the bench scenarios and its reference model. This covers the oldest-hit choice, the fallback to the oldest entry, order preservation after removal from the middle of a queue, the bank closing after a close-policy access, and the priority of an event arriving in the same cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Strobes from control to the queue datapath.
  typedef struct packed {
    logic rdPush;
    logic wrPush;
    logic rdPop;
    logic wrPop;
  } sched_strobe_t;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH  = 32,
  parameter int TAG_W  = 6,
  parameter int COL_W  = 4,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 9
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             push,
  input  logic                             pop,
  input  logic [COL_W+BANK_W+ROW_W-1:0]    inAddr,
  input  logic [TAG_W-1:0]                 inTag,
  input  logic                             rowHitMode,
  input  logic                             pageOpen,
  input  logic [(1<<BANK_W)-1:0]           openVld,
  input  logic [(1<<BANK_W)*ROW_W-1:0]     openRowFlat,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic [COL_W+BANK_W+ROW_W-1:0]    outAddr,
  output logic [TAG_W-1:0]                 outTag,
  output logic                             outHit
);
  localparam int ADDR_W = COL_W + BANK_W + ROW_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [TAG_W-1:0]  tagQ  [DEPTH];
  logic [DEPTH-1:0]  hitVec;
  logic [IDX_W-1:0]  pickIdx;
  logic [CNT_W-1:0]  wrPos;

  // Per-entry row-hit detection against the open-row table.
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    logic [BANK_W-1:0] entBank;
    logic [ROW_W-1:0]  entRow;
    assign entBank = addrQ[i][COL_W +: BANK_W];
    assign entRow  = addrQ[i][COL_W+BANK_W +: ROW_W];
    assign hitVec[i] = (CNT_W'(i) < count) && pageOpen && openVld[entBank]
                       && (openRowFlat[entBank*ROW_W +: ROW_W] == entRow);
  end

  // Index 0 is the oldest entry; the lowest hitting index is the oldest hit.
  always_comb begin
    logic found;
    pickIdx = '0;
    found   = 1'b0;
    if (rowHitMode) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hitVec[i] && !found) begin
          pickIdx = IDX_W'(i);
          found   = 1'b1;
        end
      end
    end
  end

  assign outAddr = addrQ[pickIdx];
  assign outTag  = tagQ[pickIdx];
  assign outHit  = hitVec[pickIdx];
  assign wrPos   = count - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i] <= '0;
        tagQ[i]  <= '0;
      end
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IDX_W'(i) >= pickIdx) begin
            addrQ[i] <= addrQ[i+1];
            tagQ[i]  <= tagQ[i+1];
          end
        end
      end
      if (push) begin
        addrQ[IDX_W'(wrPos)] <= inAddr;
        tagQ[IDX_W'(wrPos)]  <= inTag;
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int WR_THRESH_PCT = 70,
  parameter int COL_W         = 4,
  parameter int BANK_W        = 3,
  parameter int ROW_W         = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pageOpen,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic                          issueReady,
  input  logic [$clog2(DEPTH+1)-1:0]    rdCount,
  input  logic [$clog2(DEPTH+1)-1:0]    wrCount,
  input  logic [COL_W+BANK_W+ROW_W-1:0] issueAddr,
  input  logic                          bankEvtValid,
  input  logic                          bankEvtAct,
  input  logic [BANK_W-1:0]             bankEvtBank,
  input  logic [ROW_W-1:0]              bankEvtRow,
  output logic                          reqReady,
  output logic                          issueValid,
  output logic                          selWrite,
  output sched_strobe_t                 strb,
  output logic [(1<<BANK_W)-1:0]        openVld,
  output logic [(1<<BANK_W)*ROW_W-1:0]  openRowFlat
);
  localparam int BANKS   = 1 << BANK_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int RAW_LVL = (DEPTH * WR_THRESH_PCT) / 100;
  localparam int DRAIN_LVL = (RAW_LVL < 1) ? 1 : RAW_LVL;

  logic drain;
  logic fire;
  logic [BANK_W-1:0] issueBank;

  assign drain      = wrCount >= CNT_W'(DRAIN_LVL);
  assign issueValid = (rdCount != '0) || (wrCount != '0);
  assign selWrite   = (wrCount != '0) && (drain || rdCount == '0);
  assign reqReady   = reqWrite ? (wrCount != CNT_W'(DEPTH)) : (rdCount != CNT_W'(DEPTH));
  assign fire       = issueValid && issueReady;
  assign issueBank  = issueAddr[COL_W +: BANK_W];

  always_comb begin
    strb.rdPush = reqValid && reqReady && !reqWrite;
    strb.wrPush = reqValid && reqReady && reqWrite;
    strb.rdPop  = fire && !selWrite;
    strb.wrPop  = fire && selWrite;
  end

  // Open-row table: events win over the close-policy closing.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openVld[b] <= 1'b0;
        openRowFlat[b*ROW_W +: ROW_W] <= '0;
      end else if (bankEvtValid && bankEvtBank == BANK_W'(b)) begin
        openVld[b] <= bankEvtAct;
        if (bankEvtAct) openRowFlat[b*ROW_W +: ROW_W] <= bankEvtRow;
      end else if (fire && !pageOpen && issueBank == BANK_W'(b)) begin
        openVld[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import sched_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int WR_THRESH_PCT = 70,
  parameter int TAG_W         = 6,
  parameter int COL_W         = 4,
  parameter int BANK_W        = 3,
  parameter int ROW_W         = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rowHitMode,
  input  logic                          pageOpen,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [COL_W+BANK_W+ROW_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]              reqTag,
  output logic                          issueValid,
  input  logic                          issueReady,
  output logic                          issueWrite,
  output logic [COL_W+BANK_W+ROW_W-1:0] issueAddr,
  output logic [TAG_W-1:0]              issueTag,
  output logic                          issueHit,
  input  logic                          bankEvtValid,
  input  logic                          bankEvtAct,
  input  logic [BANK_W-1:0]             bankEvtBank,
  input  logic [ROW_W-1:0]              bankEvtRow
);
  localparam int ADDR_W = COL_W + BANK_W + ROW_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int BANKS  = 1 << BANK_W;

  sched_strobe_t         strb;
  logic [CNT_W-1:0]      rdCount, wrCount;
  logic [ADDR_W-1:0]     rdAddr, wrAddr;
  logic [TAG_W-1:0]      rdTag, wrTag;
  logic                  rdHit, wrHit;
  logic [BANKS-1:0]      openVld;
  logic [BANKS*ROW_W-1:0] openRowFlat;
  logic                  selWrite;

  assign issueWrite = selWrite;
  assign issueAddr  = selWrite ? wrAddr : rdAddr;
  assign issueTag   = selWrite ? wrTag  : rdTag;
  assign issueHit   = issueValid && (selWrite ? wrHit : rdHit);

  sched_ctrl #(.DEPTH(DEPTH), .WR_THRESH_PCT(WR_THRESH_PCT),
               .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageOpen(pageOpen),
    .reqValid(reqValid), .reqWrite(reqWrite), .issueReady(issueReady),
    .rdCount(rdCount), .wrCount(wrCount), .issueAddr(issueAddr),
    .bankEvtValid(bankEvtValid), .bankEvtAct(bankEvtAct),
    .bankEvtBank(bankEvtBank), .bankEvtRow(bankEvtRow),
    .reqReady(reqReady), .issueValid(issueValid), .selWrite(selWrite),
    .strb(strb), .openVld(openVld), .openRowFlat(openRowFlat)
  );

  sched_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .COL_W(COL_W),
                .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rdq (
    .clk(clk), .rstN(rstN), .push(strb.rdPush), .pop(strb.rdPop),
    .inAddr(reqAddr), .inTag(reqTag), .rowHitMode(rowHitMode),
    .pageOpen(pageOpen), .openVld(openVld), .openRowFlat(openRowFlat),
    .count(rdCount), .outAddr(rdAddr), .outTag(rdTag), .outHit(rdHit)
  );

  sched_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .COL_W(COL_W),
                .BANK_W(BANK_W), .ROW_W(ROW_W)) u_wrq (
    .clk(clk), .rstN(rstN), .push(strb.wrPush), .pop(strb.wrPop),
    .inAddr(reqAddr), .inTag(reqTag), .rowHitMode(rowHitMode),
    .pageOpen(pageOpen), .openVld(openVld), .openRowFlat(openRowFlat),
    .count(wrCount), .outAddr(wrAddr), .outTag(wrTag), .outHit(wrHit)
  );
endmodule

// File: rtl/sched_checker.sv
module sched_checker
  import sched_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int WR_THRESH_PCT = 70
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pageOpen,
  input logic                       reqWrite,
  input logic                       reqReady,
  input logic                       issueValid,
  input logic                       issueWrite,
  input logic                       issueHit,
  input logic [$clog2(DEPTH+1)-1:0] rdCount,
  input logic [$clog2(DEPTH+1)-1:0] wrCount,
  input sched_strobe_t              strb
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int RAW_LVL = (DEPTH * WR_THRESH_PCT) / 100;
  localparam int LVL     = (RAW_LVL < 1) ? 1 : RAW_LVL;

  p_read_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount == CNT_W'(DEPTH) && !reqWrite) |-> !reqReady);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount <= CNT_W'(DEPTH)) && (wrCount <= CNT_W'(DEPTH)));

  p_rd_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rdCount == $past(rdCount) + CNT_W'($past(strb.rdPush)) - CNT_W'($past(strb.rdPop)));

  p_wr_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> wrCount == $past(wrCount) + CNT_W'($past(strb.wrPush)) - CNT_W'($past(strb.wrPop)));

  p_read_pref_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount < CNT_W'(LVL) && rdCount != '0) |-> (issueValid && !issueWrite));

  p_drain_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount >= CNT_W'(LVL)) |-> (issueValid && issueWrite));

  p_writes_alone_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount == '0 && wrCount != '0) |-> issueWrite);

  p_close_nohit_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pageOpen |-> !issueHit);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueValid == (rdCount != '0 || wrCount != '0));
endmodule

bind rowhit_sched sched_checker #(.DEPTH(DEPTH), .WR_THRESH_PCT(WR_THRESH_PCT)) u_chk (
  .clk(clk), .rstN(rstN), .pageOpen(pageOpen), .reqWrite(reqWrite),
  .reqReady(reqReady), .issueValid(issueValid), .issueWrite(issueWrite),
  .issueHit(issueHit), .rdCount(rdCount), .wrCount(wrCount), .strb(strb)
);

// File: tb/test_rowhit_sched.sv
module test_rowhit_sched;
  localparam int DEPTH = 32;
  localparam int LVL   = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowHitMode = 1'b0, pageOpen = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [5:0]  reqTag = '0;
  logic issueReady = 1'b0;
  logic bankEvtValid = 1'b0, bankEvtAct = 1'b0;
  logic [2:0] bankEvtBank = '0;
  logic [8:0] bankEvtRow = '0;
  logic reqReady, issueValid, issueWrite, issueHit;
  logic [15:0] issueAddr;
  logic [5:0]  issueTag;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [15:0] addr; logic [5:0] tag; } ent_t;
  ent_t rq[$], wq[$];
  bit   openV[8];
  int   openR[8];

  always #4 clk = ~clk;

  rowhit_sched i_rowhit_sched (
    .clk(clk), .rstN(rstN), .rowHitMode(rowHitMode), .pageOpen(pageOpen),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqTag(reqTag), .issueValid(issueValid),
    .issueReady(issueReady), .issueWrite(issueWrite), .issueAddr(issueAddr),
    .issueTag(issueTag), .issueHit(issueHit), .bankEvtValid(bankEvtValid),
    .bankEvtAct(bankEvtAct), .bankEvtBank(bankEvtBank), .bankEvtRow(bankEvtRow)
  );

  function automatic logic [15:0] mk(int bank, int row, int col);
    return {row[8:0], bank[2:0], col[3:0]};
  endfunction

  function automatic bit hitOf(logic [15:0] a);
    return pageOpen && openV[a[6:4]] && (openR[a[6:4]] == int'(a[15:7]));
  endfunction

  function automatic int pickIn(ref ent_t q[$]);
    if (rowHitMode)
      foreach (q[i]) if (hitOf(q[i].addr)) return i;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Compare against the model, then advance one clock and update the model.
  task automatic cyc();
    bit expValid, selW, expReady, reqFire, issFire, closeIt;
    int idx, cBank;
    ent_t e;
    string ordReq;
    #1;
    expValid = (rq.size() != 0) || (wq.size() != 0);
    selW     = (wq.size() != 0) && (wq.size() >= LVL || rq.size() == 0);
    expReady = reqWrite ? (wq.size() != DEPTH) : (rq.size() != DEPTH);
    idx      = 0;
    if (expValid) idx = selW ? pickIn(wq) : pickIn(rq);
    ordReq   = rowHitMode ? "R4" : "R3";
    if (rstN) begin
      chk(issueValid == expValid, "R11 issueValid", issueValid, expValid);
      chk(reqReady == expReady, "R2 reqReady", reqReady, expReady);
      if (expValid) begin
        e = selW ? wq[idx] : rq[idx];
        chk(issueWrite == selW, "R5 R6 R7 issueWrite", issueWrite, selW);
        chk(issueTag == e.tag, {ordReq, " issueTag"}, issueTag, e.tag);
        chk(issueAddr == e.addr, {ordReq, " issueAddr"}, issueAddr, e.addr);
        chk(issueHit == hitOf(e.addr), "R1 R8 R9 issueHit", issueHit, hitOf(e.addr));
      end
    end
    reqFire = rstN && reqValid && expReady;
    issFire = rstN && issueReady && expValid;
    closeIt = issFire && !pageOpen;
    cBank   = 0;
    if (issFire) begin
      e = selW ? wq[idx] : rq[idx];
      cBank = e.addr[6:4];
      if (selW) wq.delete(idx); else rq.delete(idx);
    end
    if (reqFire) begin
      e.addr = reqAddr; e.tag = reqTag;
      if (reqWrite) wq.push_back(e); else rq.push_back(e);
    end
    if (closeIt) openV[cBank] = 0;
    if (rstN && bankEvtValid) begin
      openV[bankEvtBank] = bankEvtAct;
      if (bankEvtAct) openR[bankEvtBank] = bankEvtRow;
    end
    if (!rstN) begin
      rq.delete(); wq.delete();
      foreach (openV[b]) begin openV[b] = 0; openR[b] = 0; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(bit w, logic [15:0] a, logic [5:0] t);
    reqValid = 1; reqWrite = w; reqAddr = a; reqTag = t;
    cyc();
    reqValid = 0;
  endtask

  task automatic evt(bit act, int bank, int row);
    bankEvtValid = 1; bankEvtAct = act; bankEvtBank = bank[2:0]; bankEvtRow = row[8:0];
    cyc();
    bankEvtValid = 0;
  endtask

  task automatic drain();
    issueReady = 1;
    for (int i = 0; i < 70; i++) cyc();
    issueReady = 0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rstN = 1;
    cyc();
    // R11: empty after reset, R2: ready high
    chk(issueValid == 0, "R11 reset idle", issueValid, 0);
    chk(reqReady == 1, "R2 reset ready", reqReady, 1);

    // R3: arrival order ignores an open row
    rowHitMode = 0;
    push(0, mk(1, 5, 0), 1); push(0, mk(2, 7, 1), 2); push(0, mk(1, 9, 2), 3);
    evt(1, 1, 9);
    chk(issueTag == 1, "R3 oldest first", issueTag, 1);
    drain();

    // R4 and R1/R8: oldest hit wins, then fallback to oldest after precharge
    rowHitMode = 1;
    push(0, mk(1, 5, 0), 4); push(0, mk(2, 7, 1), 5); push(0, mk(1, 9, 2), 6);
    push(0, mk(1, 9, 3), 7);
    chk(issueTag == 6 && issueHit, "R4 oldest hit", issueTag, 6);
    evt(0, 1, 0);
    chk(issueTag == 4 && !issueHit, "R4 R8 no hit oldest", issueTag, 4);
    evt(1, 2, 7);
    chk(issueTag == 5, "R1 R8 activate hit", issueTag, 5);
    // R10: removal from the middle keeps order, push in same cycle
    issueReady = 1; reqValid = 1; reqWrite = 0; reqAddr = mk(3, 1, 0); reqTag = 8;
    cyc();
    reqValid = 0; issueReady = 0;
    cyc();
    chk(issueTag == 4, "R10 order kept after middle removal", issueTag, 4);
    drain();

    // R7: writes alone are served; R5: a read then takes precedence
    push(1, mk(0, 2, 0), 9);
    chk(issueWrite == 1, "R7 write alone", issueWrite, 1);
    push(0, mk(0, 3, 0), 10);
    chk(issueWrite == 0 && issueTag == 10, "R5 read preferred", issueTag, 10);
    drain();

    // R2 full read queue, R6 drain at level
    for (int i = 0; i < DEPTH; i++) push(0, mk(i % 4, i % 3, i), 6'(i));
    reqWrite = 0; cyc();
    chk(reqReady == 0, "R2 read full", reqReady, 0);
    reqWrite = 1; cyc();
    chk(reqReady == 1, "R2 write room", reqReady, 1);
    for (int i = 0; i < LVL - 1; i++) push(1, mk(i % 4, 1, i), 6'(40 + i));
    chk(issueWrite == 0, "R5 below level", issueWrite, 0);
    push(1, mk(2, 2, 2), 63);
    chk(issueWrite == 1, "R6 drain at level", issueWrite, 1);
    drain();

    // R9: close policy, no hit, bank closed by access, event priority
    evt(1, 3, 1);
    push(0, mk(3, 1, 0), 11); push(0, mk(3, 1, 1), 12);
    pageOpen = 0; cyc();
    chk(issueHit == 0, "R9 close no hit", issueHit, 0);
    issueReady = 1; cyc(); issueReady = 0;
    pageOpen = 1; cyc();
    chk(issueHit == 0, "R9 bank closed after access", issueHit, 0);
    push(0, mk(3, 1, 2), 13);
    pageOpen = 0; issueReady = 1;
    bankEvtValid = 1; bankEvtAct = 1; bankEvtBank = 3; bankEvtRow = 1;
    cyc();
    bankEvtValid = 0; issueReady = 0; pageOpen = 1; cyc();
    chk(issueHit == 1, "R9 event beats close", issueHit, 1);
    drain();

    // Random traffic across all modes
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        rowHitMode = $urandom_range(0, 1);
        pageOpen = $urandom_range(0, 3) != 0;
      end
      reqValid = $urandom_range(0, 2) != 0;
      reqWrite = $urandom_range(0, 1);
      reqAddr = mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15));
      reqTag = 6'($urandom);
      issueReady = $urandom_range(0, 3) < (i % 1000 < 500 ? 1 : 3);
      bankEvtValid = $urandom_range(0, 3) == 0;
      bankEvtAct = $urandom_range(0, 2) != 0;
      bankEvtBank = 3'($urandom_range(0, 3));
      bankEvtRow = 9'($urandom_range(0, 3));
      cyc();
    end
    reqValid = 0; bankEvtValid = 0;
    drain();
    chk(issueValid == 0, "R11 empty at end", issueValid, 0);

    done = 1;
    finishRun();
  end
endmodule